// File: doc/BRIEF.md
# Latched Bridge Fault Guard

This block gathers the digital fault indications around a pair of H-bridge drivers and turns them into one output-disable for the bridges. Each phase supplies an overcurrent flag, and the block also takes an over-temperature flag, two supply-good flags (motor supply and logic supply) and the two-bit excitation-mode select. All of these arrive from other clock domains or from analog comparators, so each one passes through a two-flop synchronizer first.

Timing comes from the chopper oscillator. The block samples that oscillator and counts its rising edges. An overcurrent must stay present for a programmable number of oscillator edges before it trips, so that short switching spikes are ignored. Overcurrent and thermal trips are sticky. They release only when the mode select is driven to its standby code while the offending flag has gone away, or when the block is reset. A supply that is not good holds the bridges off with no latch, and the hold lifts as soon as both supplies are good again. The standby mode code also holds the bridges off.

Top module: `fault_guard`

## Requirements
- R1: After reset all fault status outputs and `standby_forced` are 0. `drv_disable` is 1 until the synchronized supply flags are good and the mode is not standby.
- R2: An overcurrent on phase p latches `flt_oc[p]` once MASK_EDGES (default 4) rising edges of `osc_in` have been counted while the synchronized flag stayed high. Fewer edges do not trip.
- R3: When the overcurrent flag of a phase drops before the count completes, that phase's edge count restarts from zero.
- R4: A latched overcurrent sets only its own phase's `flt_oc` bit, and it asserts both `drv_disable` and `standby_forced`.
- R5: A high over-temperature flag latches `flt_ot` and asserts `drv_disable`. It does not assert `standby_forced`.
- R6: A latched fault clears only when the synchronized mode select equals 2'b00 (both bits low) and that fault's own flag is low. With mode 2'b00 and the flag still high, the fault stays latched.
- R7: When `vm_good` or `vcc_good` is low, `drv_disable` is 1 and `flt_supply` is 1. Nothing is latched, and both release once both supplies are good.
- R8: Mode select 2'b00 is standby and holds `drv_disable` at 1. Codes 2'b01, 2'b10 and 2'b11 are running modes.
- R9: Each rising edge of `osc_in` counts once, however long the oscillator stays high.
- R10: The phases are independent. An overcurrent on one phase neither advances the other phase's count nor sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| osc_in | input | 1 | Chopper oscillator, asynchronous |
| oc_flag | input | NUM_PH | Per-phase overcurrent flag, asynchronous |
| ot_flag | input | 1 | Over-temperature flag, asynchronous |
| vm_good | input | 1 | Motor supply good |
| vcc_good | input | 1 | Logic supply good |
| mode_sel | input | 2 | Excitation mode select, 2'b00 = standby |
| drv_disable | output | 1 | Turns off all bridge switches |
| flt_oc | output | NUM_PH | Latched overcurrent, per phase |
| flt_ot | output | 1 | Latched over-temperature |
| flt_supply | output | 1 | A supply is currently not good |
| standby_forced | output | 1 | Standby forced by an overcurrent latch |

## Verification
The bench uses the defaults: two phases, a mask of four oscillator edges and two synchronizer stages. A mask of four lets a few oscillator pulses land on either side of the trip threshold, including a restarted count after a spike. Two phases are enough to show that one phase's count and status leave the other's alone. Between the directed cases, random steps interleave oscillator pulses with flag, mode and supply changes. These steps drive the release rule through mode changes while flags are still high as well as after they have dropped.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'b00,
        MODE_FULL    = 2'b01,
        MODE_HALF    = 2'b10,
        MODE_QUARTER = 2'b11
    } mode_e;

    // Latch release happens only in the standby code.
    function automatic logic is_release(input logic [1:0] m);
        return m == MODE_STANDBY;
    endfunction

    typedef struct packed {
        logic       vm_ok;
        logic       vcc_ok;
        logic       ot;
    } misc_flags_t;

endpackage

// File: rtl/fg_sync.sv
module fg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/fg_edge.sv
module fg_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/fg_oc_mask.sv
module fg_oc_mask #(
    parameter int MASK_EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_s,
    input  logic tick,
    output logic trip
);
    localparam int CW = $clog2(MASK_EDGES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MASK_EDGES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !oc_s)               cnt <= '0;
        else if (tick && cnt != LIMIT)  cnt <= cnt + 1'b1;
    end

    assign trip = (cnt == LIMIT);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

    a_r3_count_restart: assert property (@(posedge clk) disable iff (rst)
        !oc_s |=> cnt == '0);

    a_r9_one_step_per_edge: assert property (@(posedge clk) disable iff (rst)
        (oc_s && !tick) |=> $stable(cnt) || !$past(oc_s) || cnt == '0);
endmodule

// File: rtl/fault_guard.sv
module fault_guard
    import fault_guard_pkg::*;
#(
    parameter int NUM_PH      = 2,
    parameter int MASK_EDGES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_in,
    input  logic [NUM_PH-1:0] oc_flag,
    input  logic              ot_flag,
    input  logic              vm_good,
    input  logic              vcc_good,
    input  logic [1:0]        mode_sel,
    output logic              drv_disable,
    output logic [NUM_PH-1:0] flt_oc,
    output logic              flt_ot,
    output logic              flt_supply,
    output logic              standby_forced
);
    localparam int SW = NUM_PH + 6;

    logic [SW-1:0]     raw_in, syn;
    logic              osc_s, tick;
    logic [NUM_PH-1:0] oc_s, trip;
    logic [1:0]        mode_s;
    misc_flags_t       misc_s;
    logic              release_s;
    logic [NUM_PH-1:0] oc_lat;
    logic              ot_lat;

    assign raw_in = {mode_sel, vm_good, vcc_good, ot_flag, oc_flag, osc_in};

    fg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(syn)
    );

    assign osc_s  = syn[0];
    assign oc_s   = syn[NUM_PH:1];
    assign misc_s = misc_flags_t'({syn[NUM_PH+3], syn[NUM_PH+2], syn[NUM_PH+1]});
    assign mode_s = syn[NUM_PH+5:NUM_PH+4];

    assign release_s = is_release(mode_s);

    fg_edge u_edge (.clk(clk), .rst(rst), .lvl(osc_s), .rise(tick));

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        fg_oc_mask #(.MASK_EDGES(MASK_EDGES)) u_mask (
            .clk(clk), .rst(rst), .oc_s(oc_s[p]), .tick(tick), .trip(trip[p])
        );

        always_ff @(posedge clk) begin
            if (rst)                           oc_lat[p] <= 1'b0;
            else if (trip[p])                  oc_lat[p] <= 1'b1;
            else if (release_s && !oc_s[p])    oc_lat[p] <= 1'b0;
        end

        a_r2_set_needs_flag: assert property (@(posedge clk) disable iff (rst)
            $rose(oc_lat[p]) |-> $past(oc_s[p]));

        a_r6_oc_clear_rule: assert property (@(posedge clk) disable iff (rst)
            $fell(oc_lat[p]) |-> $past(release_s && !oc_s[p]));
    end

    always_ff @(posedge clk) begin
        if (rst)                           ot_lat <= 1'b0;
        else if (misc_s.ot)                ot_lat <= 1'b1;
        else if (release_s)                ot_lat <= 1'b0;
    end

    assign flt_oc         = oc_lat;
    assign flt_ot         = ot_lat;
    assign flt_supply     = !(misc_s.vm_ok && misc_s.vcc_ok);
    assign standby_forced = |oc_lat;
    assign drv_disable    = (|oc_lat) | ot_lat | flt_supply | release_s;

    a_r5_ot_set_needs_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(ot_lat) |-> $past(misc_s.ot));

    a_r6_ot_clear_rule: assert property (@(posedge clk) disable iff (rst)
        $fell(ot_lat) |-> $past(release_s && !misc_s.ot));

    a_r4_latch_persists: assert property (@(posedge clk) disable iff (rst)
        (|oc_lat && !release_s) |=> |oc_lat);
endmodule

// File: tb/test_fault_guard.sv
module test_fault_guard;
    localparam int NPH  = 2;
    localparam int MASK = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc = 1'b0;
    logic [NPH-1:0] oc = '0;
    logic ot = 1'b0, vm = 1'b1, vcc = 1'b1;
    logic [1:0] mode = 2'b01;
    logic drv_disable, flt_ot, flt_supply, standby_forced;
    logic [NPH-1:0] flt_oc;

    int total = 0, bad = 0;
    bit done = 0;

    // model state
    int          m_cnt [NPH];
    logic [NPH-1:0] m_oc;
    logic        m_ot;

    always #2.5 clk = ~clk;

    fault_guard #(.NUM_PH(NPH), .MASK_EDGES(MASK), .SYNC_STAGES(2)) i_fault_guard (
        .clk(clk), .rst(rst), .osc_in(osc), .oc_flag(oc), .ot_flag(ot),
        .vm_good(vm), .vcc_good(vcc), .mode_sel(mode),
        .drv_disable(drv_disable), .flt_oc(flt_oc), .flt_ot(flt_ot),
        .flt_supply(flt_supply), .standby_forced(standby_forced)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic waitc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse();
        osc = 1'b1; waitc(4);
        osc = 1'b0; waitc(4);
    endtask

    function automatic logic exp_dis();
        return (|m_oc) | m_ot | !vm | !vcc | (mode == 2'b00);
    endfunction

    // step the model after one settled action; pulsed=1 when an osc edge occurred
    task automatic model_step(input bit pulsed);
        for (int p = 0; p < NPH; p++) begin
            if (!oc[p]) m_cnt[p] = 0;
            else if (pulsed && m_cnt[p] < MASK) m_cnt[p]++;
            if (m_cnt[p] == MASK) m_oc[p] = 1'b1;
            else if (mode == 2'b00 && !oc[p]) m_oc[p] = 1'b0;
        end
        if (ot) m_ot = 1'b1;
        else if (mode == 2'b00) m_ot = 1'b0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, "/R4 flt_oc"}, 32'(flt_oc), 32'(m_oc));
        chk({tag, "/R5 flt_ot"}, 32'(flt_ot), 32'(m_ot));
        chk({tag, "/R7 flt_supply"}, 32'(flt_supply), 32'(!(vm && vcc)));
        chk({tag, "/R4 standby"}, 32'(standby_forced), 32'(|m_oc));
        chk({tag, "/R8 disable"}, 32'(drv_disable), 32'(exp_dis()));
    endtask

    task automatic act_settle(input bit pulsed);
        if (!pulsed) waitc(8);
        model_step(pulsed);
        check_all("step");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1357));
        for (int p = 0; p < NPH; p++) m_cnt[p] = 0;
        m_oc = '0; m_ot = 1'b0;
        waitc(4);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 flt_oc", 32'(flt_oc), 0);
        chk("R1 flt_ot", 32'(flt_ot), 0);
        chk("R1 standby", 32'(standby_forced), 0);
        chk("R1 disable during sync", 32'(drv_disable), 1);
        waitc(8);
        chk("R1 disable released", 32'(drv_disable), 0);

        // R2: three edges no trip, fourth trips
        oc[0] = 1'b1; waitc(8);
        pulse(); pulse(); pulse(); waitc(4);
        chk("R2 no trip after 3 edges", 32'(flt_oc), 0);
        pulse(); waitc(4);
        chk("R2 trip after 4 edges", 32'(flt_oc), 32'b01);
        chk("R4 standby forced", 32'(standby_forced), 1);
        chk("R4 disable", 32'(drv_disable), 1);
        chk("R10 other phase clear", 32'(flt_oc[1]), 0);
        // R6: mode 00 with flag high holds
        mode = 2'b00; waitc(8);
        chk("R6 held while flag high", 32'(flt_oc), 32'b01);
        oc[0] = 1'b0; waitc(8);
        chk("R6 cleared in standby", 32'(flt_oc), 0);
        chk("R8 standby disables", 32'(drv_disable), 1);
        mode = 2'b10; waitc(8);
        chk("R8 running enables", 32'(drv_disable), 0);

        // R3: spike restarts count
        oc[1] = 1'b1; waitc(8);
        pulse(); pulse(); pulse();
        oc[1] = 1'b0; waitc(8);
        oc[1] = 1'b1; waitc(8);
        pulse(); pulse(); pulse(); waitc(4);
        chk("R3 restart no trip", 32'(flt_oc), 0);
        // R9: long high counts once
        osc = 1'b1; waitc(40); osc = 1'b0; waitc(8);
        chk("R9 fourth edge trips phase1", 32'(flt_oc), 32'b10);
        osc = 1'b1; waitc(40); osc = 1'b0; waitc(8);
        chk("R10 phase0 untouched", 32'(flt_oc[0]), 0);
        oc[1] = 1'b0; waitc(8);
        chk("R6 mode 10 does not clear", 32'(flt_oc), 32'b10);
        mode = 2'b00; waitc(8); mode = 2'b11; waitc(8);
        chk("R6 release then run", 32'(flt_oc), 0);

        // R5: thermal
        ot = 1'b1; waitc(8); ot = 1'b0; waitc(8);
        chk("R5 ot latched", 32'(flt_ot), 1);
        chk("R5 no standby", 32'(standby_forced), 0);
        chk("R5 disable", 32'(drv_disable), 1);
        mode = 2'b00; waitc(8); mode = 2'b01; waitc(8);
        chk("R6 ot cleared", 32'(flt_ot), 0);

        // R7: supply hold
        vm = 1'b0; waitc(8);
        chk("R7 vm low disables", 32'(drv_disable), 1);
        chk("R7 supply status", 32'(flt_supply), 1);
        vm = 1'b1; vcc = 1'b0; waitc(8);
        chk("R7 vcc low disables", 32'(drv_disable), 1);
        vcc = 1'b1; waitc(8);
        chk("R7 release", 32'(drv_disable), 0);
        chk("R7 no latch", 32'(flt_supply), 0);

        // random phase, model from known state
        for (int p = 0; p < NPH; p++) m_cnt[p] = 0;
        m_oc = '0; m_ot = 1'b0;
        for (int s = 0; s < 600; s++) begin
            int r;
            r = $urandom % 10;
            if (r < 5) begin
                pulse();
                act_settle(1);
            end else if (r < 7) begin
                oc[$urandom % NPH] = ($urandom % 3) != 0;
                act_settle(0);
            end else if (r == 7) begin
                ot = ($urandom % 4) == 0;
                act_settle(0);
            end else if (r == 8) begin
                mode = 2'($urandom);
                act_settle(0);
            end else begin
                vm  = ($urandom % 5) != 0;
                vcc = ($urandom % 5) != 0;
                act_settle(0);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule